// File: doc/BRIEF.md
# Strided Element-Wise Operation Engine

This block is a small memory-mastering accelerator. Given the 32-bit word address of a nine-word argument record, it loads three long pointers (two sources and one destination), an element count, a single stride and an operation word. It then walks all three streams together. For each element it reads source A, reads source B, combines them with the selected 16-bit operation and writes the result to the destination stream.

Every stream keeps a 16-bit offset that starts at zero and advances by the shared stride after each of that stream's accesses. A carry out of the offset adds one to the stream's high base half, so the effective address of element k is always base + k*stride, taken over 32 bits.

Software starts the engine with a one-cycle `start` pulse and waits for a one-cycle `done` pulse. Memory is reached through a word port that allows one outstanding access at a time: a request stays asserted until it is acknowledged.

The controller has six states. `S_IDLE` moves to `S_ARG` on `start`. `S_ARG` makes nine record reads and moves to `S_CHECK` after the acknowledge of the last one. `S_CHECK` moves to `S_IDLE` and pulses `done` when the remaining count is zero; otherwise it decrements the count and moves to `S_RDA`. `S_RDA` moves to `S_RDB` on acknowledge. `S_RDB` moves to `S_WR` on acknowledge. `S_WR` returns to `S_CHECK` on acknowledge.

Top module: `stride_op_engine`

## Requirements
- R1: After `start`, the engine reads the nine record words at arg_ptr+0 through arg_ptr+8, in increasing order. Word 0/1 is the low/high half of source A's base, word 2/3 is source B's base, word 4/5 is the destination base, word 6 is the count, word 7 is the stride and word 8 is the operation word.
- R2: For element k the engine reads A at baseA+k*stride, then reads B at baseB+k*stride, then writes the destination at baseD+k*stride, before it starts element k+1.
- R3: The low three bits of the operation word select the operation: 0 is A+B modulo 2^16, 1 is A-B modulo 2^16, 2 is A AND B, 3 is A OR B, 4 is A XOR B.
- R4: Operation codes 5, 6 and 7 write A unchanged.
- R5: Bits 15:3 of the operation word have no effect on the result.
- R6: A count of zero makes no element access. `done` pulses right after the record reads.
- R7: When a stream offset plus the stride carries out of 16 bits, that stream's high base half increments, so addresses keep following base+k*stride past 64K boundaries.
- R8: `done` is high for exactly one cycle at the end of each operation, and only while no request is pending. A `start` that arrives while the engine is busy is ignored.
- R9: After reset, `done` and `mem_req` are low.
- R10: A request holds `mem_req`, `mem_addr` and `mem_we` steady until `mem_ack`.
- R11: A `start` that arrives in the same cycle as `done` is accepted, and a new record fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start request |
| arg_ptr | input | 32 | Word address of the argument record |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completed (read data valid) |
| mem_rdata | input | 16 | Read data |

## Verification
Two functions can land in the same cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench raises `start` for a second record at the very edge where `done` is observed. It then judges the result by the complete access trace of that second run, which must begin with a fresh record fetch, and by `done` having dropped one cycle later. A second overlap occurs inside a stream: an offset carry and the element access that uses the incremented high half. A stride of 0x6000 forces it, and each reported address is compared with base+k*stride.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARG,
        S_CHECK,
        S_RDA,
        S_RDB,
        S_WR
    } sop_state_t;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } sop_op_t;

    localparam int REC_WORDS = 9;
    localparam int OFS_CNT   = 6;
    localparam int OFS_DLT   = 7;
    localparam int OFS_OP    = 8;
    localparam int NSTREAM   = 3;

endpackage

// File: rtl/sop_alu.sv
module sop_alu
    import sop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    code,
    output logic [DW-1:0] y
);

    always_comb begin
        case (code)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end

    // R4
    always_comb begin
        if (code > 3'd4) begin
            pass_a_chk: assert (y == a);
        end
    end

endmodule

// File: rtl/sop_stream.sv
module sop_stream #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_lo,
    input  logic          load_hi,
    input  logic [DW-1:0] ld_data,
    input  logic          step,
    input  logic [DW-1:0] stride,
    output logic [AW-1:0] addr
);

    localparam int HW = AW - DW;

    logic [DW-1:0] lo_q, off_q;
    logic [HW-1:0] hi_q;
    logic [DW:0]   sum;

    assign sum  = {1'b0, off_q} + {1'b0, stride};
    assign addr = {hi_q, lo_q} + AW'(off_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            off_q <= '0;
        end else begin
            if (load_lo) begin
                lo_q  <= ld_data;
                off_q <= '0;
            end
            if (load_hi) begin
                hi_q <= HW'(ld_data);
            end
            if (step) begin
                off_q <= sum[DW-1:0];
                if (sum[DW]) begin
                    hi_q <= hi_q + 1'b1;
                end
            end
        end
    end

    // R7
    carry_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sum[DW] && !load_hi) |=> (hi_q == $past(hi_q) + 1'b1));

endmodule

// File: rtl/stride_op_engine.sv
module stride_op_engine
    import sop_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] arg_ptr,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int IDXW = $clog2(REC_WORDS + 1);

    sop_state_t    state, nxt;
    logic [IDXW-1:0] idx;
    logic [AW-1:0] ptr;
    logic [DW-1:0] cnt, stride, a_val, b_val, alu_y;
    logic [2:0]    opc;

    logic [NSTREAM-1:0] ld_lo, ld_hi, st_step;
    logic [AW-1:0]      s_addr [NSTREAM];

    generate
        for (genvar i = 0; i < NSTREAM; i++) begin : g_stream
            assign ld_lo[i] = (state == S_ARG) && mem_ack && (idx == IDXW'(2 * i));
            assign ld_hi[i] = (state == S_ARG) && mem_ack && (idx == IDXW'(2 * i + 1));
            sop_stream #(.AW(AW), .DW(DW)) u_stream (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_lo (ld_lo[i]),
                .load_hi (ld_hi[i]),
                .ld_data (mem_rdata),
                .step    (st_step[i]),
                .stride  (stride),
                .addr    (s_addr[i])
            );
        end
    endgenerate

    assign st_step[0] = (state == S_RDA) && mem_ack;
    assign st_step[1] = (state == S_RDB) && mem_ack;
    assign st_step[2] = (state == S_WR)  && mem_ack;

    sop_alu #(.DW(DW)) u_alu (
        .a    (a_val),
        .b    (b_val),
        .code (opc),
        .y    (alu_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_ARG;
            S_ARG:   if (mem_ack && idx == IDXW'(OFS_OP)) nxt = S_CHECK;
            S_CHECK: nxt = (cnt == '0) ? S_IDLE : S_RDA;
            S_RDA:   if (mem_ack) nxt = S_RDB;
            S_RDB:   if (mem_ack) nxt = S_WR;
            S_WR:    if (mem_ack) nxt = S_CHECK;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            ptr    <= '0;
            cnt    <= '0;
            stride <= '0;
            opc    <= '0;
            a_val  <= '0;
            b_val  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    ptr <= arg_ptr;
                    idx <= '0;
                end
                S_ARG: if (mem_ack) begin
                    idx <= idx + 1'b1;
                    if (idx == IDXW'(OFS_CNT)) cnt    <= mem_rdata;
                    if (idx == IDXW'(OFS_DLT)) stride <= mem_rdata;
                    if (idx == IDXW'(OFS_OP))  opc    <= mem_rdata[2:0];
                end
                S_CHECK: begin
                    if (cnt == '0) done <= 1'b1;
                    else           cnt  <= cnt - 1'b1;
                end
                S_RDA: if (mem_ack) a_val <= mem_rdata;
                S_RDB: if (mem_ack) b_val <= mem_rdata;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = alu_y;
        unique case (state)
            S_ARG: begin
                mem_req  = 1'b1;
                mem_addr = ptr + AW'(idx);
            end
            S_RDA: begin
                mem_req  = 1'b1;
                mem_addr = s_addr[0];
            end
            S_RDB: begin
                mem_req  = 1'b1;
                mem_addr = s_addr[1];
            end
            S_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_addr[2];
            end
            default: ;
        endcase
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && state == S_IDLE));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && cnt == '0) |=> (done && !mem_req));

endmodule

// File: tb/stride_op_engine_test.sv
`timescale 1ns/1ps
module stride_op_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] arg_ptr = '0;
    logic        done, mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;
    int wait_cnt = 0;

    logic [15:0] mem [logic [31:0]];
    logic        lg_we   [64];
    logic [31:0] lg_addr [64];
    logic [15:0] lg_data [64];
    int          nlog = 0;

    // fields: op(16) cnt(16) stride(16) A(32) B(32) D(32)
    localparam int NV = 10;
    localparam logic [143:0] VEC [NV] = '{
        {16'h0000, 16'd5, 16'd1,    32'h0001_0000, 32'h0002_0100, 32'h0003_0000},
        {16'h0001, 16'd4, 16'd3,    32'h0001_2000, 32'h0002_2000, 32'h0003_2000},
        {16'h0002, 16'd3, 16'd2,    32'h0001_4000, 32'h0002_4000, 32'h0003_4000},
        {16'h0003, 16'd3, 16'd7,    32'h0001_5000, 32'h0002_5000, 32'h0003_5000},
        {16'h0004, 16'd3, 16'd1,    32'h0001_6000, 32'h0002_6000, 32'h0003_6000},
        {16'hFFF5, 16'd3, 16'd1,    32'h0001_7000, 32'h0002_7000, 32'h0003_7000},
        {16'hABC9, 16'd2, 16'd4,    32'h0001_8000, 32'h0002_8000, 32'h0003_8000},
        {16'h0006, 16'd4, 16'h6000, 32'h0004_1000, 32'h0005_F000, 32'h0009_F000},
        {16'h0007, 16'd0, 16'd1,    32'h0001_9000, 32'h0002_9000, 32'h0003_9000},
        {16'h0000, 16'd2, 16'd0,    32'h0001_A000, 32'h0002_A000, 32'h0003_A000}
    };

    stride_op_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_ptr(arg_ptr), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] pat(input logic [31:0] a);
        return (a[15:0] * 16'd40503) ^ a[31:16] ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return pat(a);
    endfunction

    function automatic logic [31:0] rec_ptr(input int v);
        return 32'h0000_0100 + 32'(v) * 32'd16;
    endfunction

    function automatic logic [15:0] rec_word(input int v, input int i);
        logic [143:0] e = VEC[v];
        case (i)
            0: return e[79:64];   1: return e[95:80];
            2: return e[47:32];   3: return e[63:48];
            4: return e[15:0];    5: return e[31:16];
            6: return e[127:112]; 7: return e[111:96];
            default: return e[143:128];
        endcase
    endfunction

    function automatic logic [15:0] ref_op(input logic [15:0] opw, input logic [15:0] a,
                                           input logic [15:0] b);
        case (opw[2:0])
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            default: return a;
        endcase
    endfunction

    // memory model: acknowledges away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    mem_rdata = 16'hXXXX;
                end else begin
                    mem_rdata = rd(mem_addr);
                end
                if (nlog < 64) begin
                    lg_we[nlog]   = mem_we;
                    lg_addr[nlog] = mem_addr;
                    lg_data[nlog] = mem_we ? mem_wdata : mem_rdata;
                end
                nlog++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R8", "done seen", 32'(done), 32'd1);
    endtask

    task automatic verify(input int v);
        logic [143:0] e = VEC[v];
        logic [15:0]  opw = e[143:128];
        int           cnt = int'(e[127:112]);
        logic [31:0]  dl = 32'(e[111:96]);
        logic [31:0]  pa, pb, pd;
        logic [15:0]  va, vb;
        int           j;
        chk(nlog == 9 + 3 * cnt, (cnt == 0) ? "R6" : "R2", "access count",
            32'(nlog), 32'(9 + 3 * cnt));
        for (int i = 0; i < 9; i++) begin
            chk(!lg_we[i] && lg_addr[i] == rec_ptr(v) + 32'(i) && lg_data[i] == rec_word(v, i),
                "R1", "record read addr", lg_addr[i], rec_ptr(v) + 32'(i));
        end
        for (int k = 0; k < cnt; k++) begin
            j  = 9 + 3 * k;
            pa = e[95:64] + 32'(k) * dl;
            pb = e[63:32] + 32'(k) * dl;
            pd = e[31:0]  + 32'(k) * dl;
            va = pat(pa);
            vb = pat(pb);
            chk(!lg_we[j] && lg_addr[j] == pa, "R7", "A read addr", lg_addr[j], pa);
            chk(!lg_we[j+1] && lg_addr[j+1] == pb, "R2", "B read addr", lg_addr[j+1], pb);
            chk(lg_we[j+2] && lg_addr[j+2] == pd, "R2", "dst write addr", lg_addr[j+2], pd);
            if (opw[2:0] > 3'd4)
                chk(lg_data[j+2] == va, "R4", "pass-through data", 32'(lg_data[j+2]), 32'(va));
            else if (opw[15:3] != '0)
                chk(lg_data[j+2] == ref_op(opw, va, vb), "R5", "upper op bits",
                    32'(lg_data[j+2]), 32'(ref_op(opw, va, vb)));
            else
                chk(lg_data[j+2] == ref_op(opw, va, vb), "R3", "result data",
                    32'(lg_data[j+2]), 32'(ref_op(opw, va, vb)));
        end
    endtask

    task automatic launch(input int v);
        nlog = 0;
        start = 1'b1;
        arg_ptr = rec_ptr(v);
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        for (int v = 0; v < NV; v++)
            for (int i = 0; i < 9; i++)
                mem[rec_ptr(v) + 32'(i)] = rec_word(v, i);
        for (int i = 0; i < 9; i++)
            mem[32'h0000_0F00 + 32'(i)] = 16'hFFFF;

        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!done, "R9", "done after reset", 32'(done), 32'd0);
        chk(!mem_req, "R9", "mem_req after reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req, "R9", "idle after release", 32'({done, mem_req}), 32'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            lat = v % 3;
            @(negedge clk);
            launch(v);
            wait_done();
            @(negedge clk);
            chk(!done, "R8", "done width", 32'(done), 32'd0);
            verify(v);
        end

        // R8 start while busy is ignored
        lat = 1;
        @(negedge clk);
        launch(0);
        repeat (6) @(negedge clk);
        start = 1'b1;
        arg_ptr = 32'h0000_0F00;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        verify(0);

        // R11 start in the done cycle
        lat = 0;
        @(negedge clk);
        launch(2);
        wait_done();
        verify(2);
        launch(3);
        chk(!done, "R11", "done dropped after chained start", 32'(done), 32'd0);
        wait_done();
        verify(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule